// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 2048 bytes. The host hands over one request at a time: an 11-bit address, a direction bit, a byte of write data and a write-style selector, using a valid/ready handshake. The block then drives the memory's chip enable, output enable and write enable strobes (all active low), a registered address and a separate write-data bus with its driver enable. For a read it returns the captured byte to the host together with a valid pulse that lasts one clock.

Every analog timing window is turned into a whole number of clock cycles by rounding up, using a clock-period parameter and one of three speed grades. The windows are: access time, output-enable access, write pulse, data setup and hold, address-to-end-of-write, output turn-off after a write starts, recovery and minimum cycle time. Each write can be closed either by write enable rising first (write-enable controlled) or by chip enable rising first (chip-enable controlled). All strobes and the address come straight from flops, so they never glitch.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset, reqReady is 1 and busy is 0. sramEnN, sramOeN and sramWeN are 1, and sramDoe and rdValid are 0.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. From that edge on, reqReady stays 0 and busy stays 1 for exactly L cycles. L is 1+A+Rr for a read and 1+P+H+Rw for a write. At the default 10 ns clock and grade 0 this gives A=7, Rr=0, P=6, H=1 and Rw=0, so L is 8 for both.
- R3: A read holds sramEnN=0, sramOeN=0 and sramWeN=1 for A cycles, where A = ceil(max(70 ns, 35 ns)/period) at grade 0. The byte on sramDin is then captured. rdValid is 1 for exactly one cycle, right after edge 1+A counted from the accept edge. rdData then equals the byte stored at the address.
- R4: With reqCeCtl=0, a write ends with sramWeN rising while sramEnN stays 0 for the hold cycles.
- R5: With reqCeCtl=1, a write ends with sramEnN rising while sramWeN stays 0 for the hold cycles.
- R6: The time with both sramEnN and sramWeN at 0 is at least the grade's write pulse (50 ns at grade 0). The time from the last address change to the end of the write is at least 60 ns at grade 0.
- R7: sramDoe rises no sooner than 25 ns after the write starts. The data is driven at least 30 ns before the write ends and stays driven at least 5 ns after it (grade 0 values).
- R8: sramOeN is 1 for the whole of any write. sramDoe is never 1 while sramOeN is 0.
- R9: sramAddr does not change while sramEnN is 0.
- R10: Consecutive falling edges of sramEnN are at least the grade's cycle time apart (70 ns at grade 0). Each falling edge comes at least the recovery time after the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCeCtl | input | 1 | Write style: 0 = write enable ends the write, 1 = chip enable ends it |
| reqAddr | input | 11 | Byte address |
| reqWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-cycle pulse: rdData holds read result |
| rdData | output | 8 | Captured read byte |
| busy | output | 1 | An access is in progress |
| sramAddr | output | 11 | Memory address |
| sramEnN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramDout | output | 8 | Write data to memory |
| sramDoe | output | 1 | Write data driver enable |
| sramDin | input | 8 | Read data from memory |

## Verification
The read result is due right after edge 1+A counted from the accept edge. The driver task records that cycle number next to the expected byte in a queue, and the monitor compares both the byte and the cycle when rdValid appears. Busy must last exactly L cycles from the accept edge, so the driver counts the falling clock edges during which reqReady stays low. The strobe windows are measured at every falling clock edge, in whole cycles, against the nanosecond limits. The memory model drives the complement of the stored byte until both the address and output-enable access times have passed, so a capture even one cycle early returns a wrong value.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  // timing items of a speed grade
  localparam int T_CYC  = 0;
  localparam int T_WP   = 1;
  localparam int T_DS   = 2;
  localparam int T_DH   = 3;
  localparam int T_AVWH = 4;
  localparam int T_WLQZ = 5;
  localparam int T_REC  = 6;
  localparam int T_AA   = 7;
  localparam int T_OE   = 8;

  typedef struct packed {
    logic enLow;
    logic oeLow;
    logic weLow;
    logic drvOn;
  } strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_HOLD,
    ST_RECOV
  } state_t;

  function automatic int gradeNs(int grade, int item);
    int v;
    v = 0;
    case (grade)
      1: case (item)
           T_CYC: v = 150; T_WP: v = 90; T_DS: v = 40; T_DH: v = 5;
           T_AVWH: v = 120; T_WLQZ: v = 50; T_REC: v = 10;
           T_AA: v = 150; T_OE: v = 75; default: v = 0;
         endcase
      2: case (item)
           T_CYC: v = 200; T_WP: v = 120; T_DS: v = 60; T_DH: v = 5;
           T_AVWH: v = 140; T_WLQZ: v = 60; T_REC: v = 10;
           T_AA: v = 200; T_OE: v = 80; default: v = 0;
         endcase
      default: case (item)
           T_CYC: v = 70; T_WP: v = 50; T_DS: v = 30; T_DH: v = 5;
           T_AVWH: v = 60; T_WLQZ: v = 25; T_REC: v = 0;
           T_AA: v = 70; T_OE: v = 35; default: v = 0;
         endcase
    endcase
    return v;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds rounded up to whole clock cycles
  function automatic int nsToCyc(int grade, int item, int clkNs);
    return (gradeNs(grade, item) + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int GRADE  = 0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     reqCe,
  output logic     reqReady,
  output logic     accept,
  output logic     capture,
  output strobes_t strobesNext
);

  localparam int N_DRV    = nsToCyc(GRADE, T_WLQZ, CLK_NS);
  localparam int N_PULSE  = imax(imax(nsToCyc(GRADE, T_WP, CLK_NS),
                                      N_DRV + nsToCyc(GRADE, T_DS, CLK_NS)),
                                 nsToCyc(GRADE, T_AVWH, CLK_NS) - 1);
  localparam int N_HOLD   = imax(1, nsToCyc(GRADE, T_DH, CLK_NS));
  localparam int N_WR_REC = imax(nsToCyc(GRADE, T_REC, CLK_NS),
                                 nsToCyc(GRADE, T_CYC, CLK_NS) - 1 - N_PULSE - N_HOLD);
  localparam int N_ACCESS = imax(1, imax(nsToCyc(GRADE, T_AA, CLK_NS),
                                         nsToCyc(GRADE, T_OE, CLK_NS)));
  localparam int N_RD_REC = imax(nsToCyc(GRADE, T_REC, CLK_NS),
                                 nsToCyc(GRADE, T_CYC, CLK_NS) - 1 - N_ACCESS);
  localparam int N_MAX    = imax(imax(N_PULSE, N_ACCESS),
                                 imax(N_HOLD, imax(N_WR_REC, N_RD_REC)));
  localparam int CW       = $clog2(N_MAX + 1);

  localparam logic [CW-1:0] L_PULSE  = CW'(N_PULSE - 1);
  localparam logic [CW-1:0] L_ACCESS = CW'(N_ACCESS - 1);
  localparam logic [CW-1:0] L_HOLD   = CW'(N_HOLD - 1);
  localparam logic [CW-1:0] L_WR_REC = CW'(imax(N_WR_REC, 1) - 1);
  localparam logic [CW-1:0] L_RD_REC = CW'(imax(N_RD_REC, 1) - 1);
  localparam logic [CW-1:0] L_DRV    = CW'(N_DRV);

  state_t        state, nState;
  logic [CW-1:0] cnt, nCnt;
  logic          isWrite, isCe, nWrite, nCe;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nState  = state;
    nCnt    = cnt;
    nWrite  = isWrite;
    nCe     = isCe;
    capture = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        nState = ST_ADDR;
        nCnt   = '0;
        nWrite = reqWrite;
        nCe    = reqCe;
      end
      ST_ADDR: begin
        nState = ST_STROBE;
        nCnt   = '0;
      end
      ST_STROBE: begin
        if (isWrite) begin
          if (cnt == L_PULSE) begin
            nState = ST_HOLD;
            nCnt   = '0;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end else begin
          if (cnt == L_ACCESS) begin
            capture = 1'b1;
            nState  = (N_RD_REC > 0) ? ST_RECOV : ST_IDLE;
            nCnt    = '0;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt == L_HOLD) begin
          nState = (N_WR_REC > 0) ? ST_RECOV : ST_IDLE;
          nCnt   = '0;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == (isWrite ? L_WR_REC : L_RD_REC)) begin
          nState = ST_IDLE;
          nCnt   = '0;
        end else begin
          nCnt = cnt + 1'b1;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  // strobes for the coming cycle, registered in the datapath
  always_comb begin
    strobesNext = '0;
    case (nState)
      ST_STROBE: begin
        strobesNext.enLow = 1'b1;
        strobesNext.oeLow = !nWrite;
        strobesNext.weLow = nWrite;
        strobesNext.drvOn = nWrite && (nCnt >= L_DRV);
      end
      ST_HOLD: begin
        strobesNext.enLow = !nCe;
        strobesNext.weLow = nCe;
        strobesNext.drvOn = 1'b1;
      end
      default: strobesNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      isCe    <= 1'b0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      isWrite <= nWrite;
      isCe    <= nCe;
    end
  end

  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R2
  capture_ends_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capture && (N_RD_REC == 0)) |=> reqReady);

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobes_t          strobesNext,
  input  logic              capture,
  input  logic [DATA_W-1:0] sramDin,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramEnN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              sramDoe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr <= '0;
      sramDout <= '0;
      sramEnN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramWeN  <= 1'b1;
      sramDoe  <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (accept) begin
        sramAddr <= reqAddr;
        sramDout <= reqWdata;
      end
      sramEnN <= !strobesNext.enLow;
      sramOeN <= !strobesNext.oeLow;
      sramWeN <= !strobesNext.weLow;
      sramDoe <= strobesNext.drvOn;
      rdValid <= capture;
      if (capture) rdData <= sramDin;
    end
  end

  // R8
  no_drive_into_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramDoe |-> sramOeN);

  // R8
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN);

  // R9
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramEnN && !$past(sramEnN)) |-> $stable(sramAddr));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7
  drv_inside_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDoe) |-> (!sramWeN && !sramEnN));

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int GRADE  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqCeCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramEnN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  input  logic [DATA_W-1:0] sramDin
);

  strobes_t strobesNext;
  logic     accept;
  logic     capture;

  sramc_ctrl #(.CLK_NS(CLK_NS), .GRADE(GRADE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqCe      (reqCeCtl),
    .reqReady   (reqReady),
    .accept     (accept),
    .capture    (capture),
    .strobesNext(strobesNext)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .accept     (accept),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .strobesNext(strobesNext),
    .capture    (capture),
    .sramDin    (sramDin),
    .sramAddr   (sramAddr),
    .sramDout   (sramDout),
    .sramEnN    (sramEnN),
    .sramOeN    (sramOeN),
    .sramWeN    (sramWeN),
    .sramDoe    (sramDoe),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  assign busy = !reqReady;

endmodule

// File: tb/sram_timing_ctrl_tb.sv
`timescale 1ns/1ps
module sram_timing_ctrl_tb;

  localparam int P      = 10;
  // grade 0 limits in ns, taken from the requirements
  localparam int TCYC   = 70;
  localparam int TWP    = 50;
  localparam int TDS    = 30;
  localparam int TDH    = 5;
  localparam int TAVWH  = 60;
  localparam int TWLQZ  = 25;
  localparam int TREC   = 0;
  localparam int TAA    = 70;
  localparam int TOE    = 35;
  localparam int N_ACC  = 7;
  localparam int RD_LEN = 8;
  localparam int WR_LEN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqCeCtl = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid, busy;
  logic [7:0]  rdData;
  logic [10:0] sramAddr;
  logic        sramEnN, sramOeN, sramWeN, sramDoe;
  logic [7:0]  sramDout;
  logic [7:0]  sramDin = '0;

  sram_timing_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqCeCtl(reqCeCtl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData), .busy(busy),
    .sramAddr(sramAddr), .sramEnN(sramEnN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .sramDout(sramDout), .sramDoe(sramDoe),
    .sramDin(sramDin)
  );

  always #(P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int pcyc = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] d; int cyc; } exp_t;
  exp_t q[$];

  logic [7:0] mem    [2048];
  logic [7:0] expMem [2048];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, pcyc);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) pcyc <= pcyc + 1;

  // ---------------- pin monitor and memory model ----------------
  bit         curCe = 1'b0;
  logic       pEn = 1'b1, pOe = 1'b1, pWe = 1'b1, pDoe = 1'b0;
  logic [10:0] pAddr = '0;
  logic [7:0] pDout = '0;
  int addrChg = 0, oeFall = 0, wrStart = 0, wrEnd = 0, drvOn = 0;
  int lastStart = -1000, lastEnRise = -1000;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit wa  = !sramEnN && !sramWeN;
      automatic bit pwa = !pEn && !pWe;
      if (sramAddr != pAddr) begin
        if (!sramEnN && !pEn) chk(1'b0, "R9", sramAddr, pAddr);
        addrChg = pcyc;
      end
      if (sramDoe && !sramOeN) chk(1'b0, "R8", sramOeN, 1);
      if (!sramEnN && pEn) begin
        chk((pcyc - lastStart) * P >= TCYC, "R10 cycle", (pcyc - lastStart) * P, TCYC);
        chk((pcyc - lastEnRise) * P >= TREC, "R10 recovery", (pcyc - lastEnRise) * P, TREC);
        lastStart = pcyc;
      end
      if (sramEnN && !pEn) lastEnRise = pcyc;
      if (!sramOeN && pOe) oeFall = pcyc;
      if (wa && !pwa) begin
        wrStart = pcyc;
        chk(sramOeN, "R8 oe in write", sramOeN, 1);
      end
      if (sramDoe && !pDoe) begin
        drvOn = pcyc;
        chk((pcyc - wrStart) * P >= TWLQZ, "R7 turnaround", (pcyc - wrStart) * P, TWLQZ);
      end
      if (!wa && pwa) begin
        wrEnd = pcyc;
        chk((pcyc - wrStart) * P >= TWP, "R6 pulse", (pcyc - wrStart) * P, TWP);
        chk((pcyc - addrChg) * P >= TAVWH, "R6 addr to end", (pcyc - addrChg) * P, TAVWH);
        chk(pDoe && (pcyc - drvOn) * P >= TDS, "R7 setup", (pcyc - drvOn) * P, TDS);
        if (curCe) chk(sramEnN && !sramWeN, "R5 E ends write", {sramEnN, sramWeN}, 2'b10);
        else       chk(!sramEnN && sramWeN, "R4 W ends write", {sramEnN, sramWeN}, 2'b01);
        mem[pAddr] = pDoe ? pDout : 8'hxx;
      end
      if (!sramDoe && pDoe)
        chk((pcyc - wrEnd) * P >= TDH, "R7 hold", (pcyc - wrEnd) * P, TDH);
      if (!sramEnN && !sramOeN && sramWeN &&
          (pcyc - addrChg) * P >= TAA && (pcyc - oeFall) * P >= TOE)
        sramDin = mem[sramAddr];
      else
        sramDin = ~mem[sramAddr];
      pEn = sramEnN; pOe = sramOeN; pWe = sramWeN; pDoe = sramDoe;
      pAddr = sramAddr; pDout = sramDout;
    end
  end

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3 unexpected rdValid", 1, 0);
      end else begin
        automatic exp_t e = q.pop_front();
        chk(rdData == e.d, "R3 data", rdData, e.d);
        chk(pcyc == e.cyc, "R3 latency", pcyc, e.cyc);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic doReq(bit wr, bit ce, logic [10:0] a, logic [7:0] d);
    int busyN = 0;
    int busyBad = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqCeCtl = ce; reqAddr = a; reqWdata = d;
    curCe = ce;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = ~a;
    reqWdata = ~d;
    if (wr) expMem[a] = d;
    else    q.push_back('{d: expMem[a], cyc: pcyc + 1 + N_ACC});
    while (!reqReady) begin
      if (!busy) busyBad++;
      busyN++;
      @(negedge clk);
    end
    chk(busyN == (wr ? WR_LEN : RD_LEN) && busyBad == 0, "R2 busy length",
        busyN, wr ? WR_LEN : RD_LEN);
  endtask

  initial begin
    #(200000 * P);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i]    = 8'(i) ^ 8'hA5;
      expMem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1 && busy == 1'b0, "R1 handshake", {reqReady, busy}, 2'b10);
    chk(sramEnN && sramOeN && sramWeN && !sramDoe && !rdValid, "R1 strobes",
        {sramEnN, sramOeN, sramWeN, sramDoe, rdValid}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);

    // reads of untouched locations (R3)
    doReq(1'b0, 1'b0, 11'h400, 8'h00);
    doReq(1'b0, 1'b0, 11'h000, 8'h00);
    // writes in both styles (R4 R5 R6 R7)
    doReq(1'b1, 1'b0, 11'h000, 8'h3C);
    doReq(1'b1, 1'b0, 11'h7FF, 8'hFF);
    doReq(1'b1, 1'b1, 11'h2AA, 8'h00);
    doReq(1'b1, 1'b1, 11'h155, 8'h81);
    doReq(1'b1, 1'b0, 11'h001, 8'h5A);
    // read back
    doReq(1'b0, 1'b0, 11'h000, 8'h00);
    doReq(1'b0, 1'b0, 11'h7FF, 8'h00);
    doReq(1'b0, 1'b1, 11'h2AA, 8'h00);
    doReq(1'b0, 1'b0, 11'h155, 8'h00);
    doReq(1'b0, 1'b0, 11'h001, 8'h00);
    // same address repeatedly, alternating styles (R9 R10)
    for (int k = 0; k < 6; k++) begin
      doReq(1'b1, k[0], 11'h123, 8'(k * 37 + 1));
      doReq(1'b0, 1'b0, 11'h123, 8'h00);
    end
    // sweep of addresses
    for (int k = 0; k < 16; k++) doReq(1'b1, k[1], 11'(k * 131), 8'(k * 17));
    for (int k = 0; k < 16; k++) doReq(1'b0, 1'b0, 11'(k * 131), 8'h00);

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R3 all reads returned", q.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule